// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block turns a synchronous host request port into the strobe and address sequence for one bank of asynchronous extended-data-out DRAM. The host presents a request flag, a write flag, a combined row-and-column address, 64 bits of write data and eight byte-lane strobes. It holds them until the one-cycle acknowledge. Read data is returned on the acknowledge cycle. The block drives an active-low row strobe, eight active-low column strobes (one per byte lane), active-low write and output enables, a multiplexed address bus and the write data bus.

After a row has been opened it stays open. A later request to the same row only runs a new column cycle (page mode). A request to a different row first closes the page, waits out the precharge and then opens the new row. Every timing limit is a nanosecond parameter. It is turned into clock cycles with a clock-period parameter, rounding up, and access-time waits get one more cycle of margin. An open page is closed by the block before the maximum row-active time runs out.

Bit 0 of the address bus exists twice: one copy feeds the devices on data bits 31..0 and the other feeds the devices on data bits 63..32. During the row phase both copies carry row bit 0. During the column phase the `INTERLEAVE` parameter chooses whether the upper-half copy is inverted. When inverted, the two 32-bit halves reach neighbouring 4-byte words, which lets them act as two interleaved banks.

Top module: `edo_page_sequencer`

## Requirements
- R1: In reset and just after it, the row strobe, every column strobe, write enable and output enable are high (inactive). The data bus driver is off and the acknowledge is low.
- R2: The row address is on the bus, unchanged, for at least one full clock cycle before the row strobe falls. At that edge both bit-0 copies equal row bit 0.
- R3: In the column phase, the lower-half bit-0 copy equals column bit 0. With INTERLEAVE=1 the upper-half copy is its inverse. Data bits 31..0 therefore use column c and bits 63..32 use column c XOR 1. The host address is {row, column}, with the column in the low COL_W bits.
- R4: For a write, write enable is low and the write data is driven and stable for at least one cycle before the column strobes fall. Only lane i, which carries data bits 8i+7..8i, has its strobe driven when byte strobe bit i is 1.
- R5: Read data is captured no sooner than the row access time plus one cycle after the row strobe fell, and no sooner than the column access time plus one cycle after the column strobes fell. It equals the stored words at the addresses given in R3.
- R6: Each request gets exactly one acknowledge pulse, one cycle wide. For a write it comes after the column strobe pulse; for a read it comes in the cycle the read data is first valid on the output.
- R7: A request to the row that is already open does not raise the row strobe.
- R8: A request to a different row raises the row strobe. The row strobe then stays high for at least the precharge time (40 ns), and two row strobe falls are at least the random cycle time (104 ns) apart.
- R9: Column strobes go low only while the row strobe is low. They stay low for at least 10 ns and high for at least 10 ns, and successive falls are at least 25 ns apart.
- R10: The row strobe never stays low longer than the page limit parameter. The page is closed even when no request arrives.
- R11: The row strobe stays low for at least the minimum row-active time (60 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | {row, column} address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane strobes for writes |
| req_ack | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | DATA_W | Read data, valid with acknowledge |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | DATA_W/8 | Column strobe per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W)-1 | Address bits above bit 0 |
| dram_a0_lo | output | 1 | Address bit 0 for data bits 31..0 |
| dram_a0_hi | output | 1 | Address bit 0 for data bits 63..32 |
| dram_dq_out | output | DATA_W | Write data to memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from memory |

## Verification
The hardest case to reach is the forced page close, where the row stays open long enough to come close to the maximum row-active time. The bench builds the block with a short page limit of 600 ns. It then sends a long run of back-to-back requests to the same row, so the close decision has to fall between two column cycles. The bench's memory model puts garbage on the data bus until both access times have passed since the strobe falls it has seen. A read captured too early therefore shows up as a data mismatch. The same model measures every strobe pulse and gap in nanoseconds.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RSET, ST_RCD, ST_COL, ST_CASL, ST_CASH, ST_PAGE, ST_PRE
  } seq_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 10,
  parameter int ADDR_W     = 12,
  parameter int INTERLEAVE = 1
) (
  input  logic [ROW_W+COL_W-1:0] host_addr,
  output logic [ADDR_W-1:1]      row_upper,
  output logic                   row_bit0,
  output logic [ADDR_W-1:1]      col_upper,
  output logic                   col_bit0_lo,
  output logic                   col_bit0_hi
);
  logic [ADDR_W-1:0] row_w;
  logic [ADDR_W-1:0] col_w;

  assign row_w = ADDR_W'(host_addr[ROW_W+COL_W-1:COL_W]);
  assign col_w = ADDR_W'(host_addr[COL_W-1:0]);

  assign row_upper   = row_w[ADDR_W-1:1];
  assign row_bit0    = row_w[0];
  assign col_upper   = col_w[ADDR_W-1:1];
  assign col_bit0_lo = col_w[0];

  generate
    if (INTERLEAVE != 0) begin : g_ilv
      assign col_bit0_hi = ~col_w[0];
    end else begin : g_flat
      assign col_bit0_hi = col_w[0];
    end
  endgenerate
endmodule

// File: rtl/edo_age_counter.sv
module edo_age_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] age
);
  always_ff @(posedge clk) begin
    if (rst)             age <= '1;
    else if (clr)        age <= '0;
    else if (age != '1)  age <= age + 1'b1;
  end
endmodule

// File: rtl/edo_page_sequencer.sv
module edo_page_sequencer
  import edo_seq_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 10,
  parameter int DATA_W     = 64,
  parameter int INTERLEAVE = 1,
  parameter int CLK_NS     = 10,
  parameter int T_ASR_NS   = 5,
  parameter int T_RCD_NS   = 20,
  parameter int T_RAS_NS   = 60,
  parameter int T_RP_NS    = 40,
  parameter int T_RC_NS    = 104,
  parameter int T_CAS_NS   = 10,
  parameter int T_CP_NS    = 10,
  parameter int T_HPC_NS   = 25,
  parameter int T_RAC_NS   = 60,
  parameter int T_CAC_NS   = 20,
  parameter int T_RASP_NS  = 100000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ROW_W+COL_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  input  logic [DATA_W/8-1:0]          req_be,
  output logic                         req_ack,
  output logic [DATA_W-1:0]            rsp_rdata,
  output logic                         dram_ras_n,
  output logic [DATA_W/8-1:0]          dram_cas_n,
  output logic                         dram_we_n,
  output logic                         dram_oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:1] dram_addr,
  output logic                         dram_a0_lo,
  output logic                         dram_a0_hi,
  output logic [DATA_W-1:0]            dram_dq_out,
  output logic                         dram_dq_oe,
  input  logic [DATA_W-1:0]            dram_dq_in
);
  localparam int LANES  = DATA_W / 8;
  localparam int HA_W   = ROW_W + COL_W;
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  localparam int ASR_C  = ns2cyc(T_ASR_NS, CLK_NS);
  localparam int RCD_C  = ns2cyc(T_RCD_NS, CLK_NS);
  localparam int RAS_C  = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int RP_C   = ns2cyc(T_RP_NS, CLK_NS);
  localparam int RC_C   = ns2cyc(T_RC_NS, CLK_NS);
  localparam int CAS_C  = ns2cyc(T_CAS_NS, CLK_NS);
  localparam int CP_C   = ns2cyc(T_CP_NS, CLK_NS);
  localparam int HPC_C  = ns2cyc(T_HPC_NS, CLK_NS);
  localparam int RAC_C  = ns2cyc(T_RAC_NS, CLK_NS) + 1;
  localparam int CAC_C  = ns2cyc(T_CAC_NS, CLK_NS) + 1;
  localparam int RASP_C = T_RASP_NS / CLK_NS;
  localparam int STRB_C = (CAC_C > CAS_C) ? CAC_C : CAS_C;
  localparam int SPAN_C = HPC_C + STRB_C + CP_C + 4;
  localparam int LIM_C  = RASP_C - SPAN_C;
  localparam int AGE_W  = $clog2(RASP_C + RC_C + 2);

  // thresholds expressed as "age reached N-1"
  localparam logic [AGE_W-1:0] K_ASR = AGE_W'(ASR_C - 1);
  localparam logic [AGE_W-1:0] K_RCD = AGE_W'(RCD_C - 1);
  localparam logic [AGE_W-1:0] K_RAS = AGE_W'(RAS_C - 1);
  localparam logic [AGE_W-1:0] K_RP  = AGE_W'(RP_C - 1);
  localparam logic [AGE_W-1:0] K_RC  = AGE_W'(RC_C - 1);
  localparam logic [AGE_W-1:0] K_CAS = AGE_W'(CAS_C - 1);
  localparam logic [AGE_W-1:0] K_CP  = AGE_W'(CP_C - 1);
  localparam logic [AGE_W-1:0] K_HPC = AGE_W'(HPC_C - 1);
  localparam logic [AGE_W-1:0] K_RAC = AGE_W'(RAC_C - 1);
  localparam logic [AGE_W-1:0] K_CAC = AGE_W'(CAC_C - 1);
  localparam logic [AGE_W-1:0] K_LIM = AGE_W'(LIM_C);

  seq_state_e        state;
  logic [AGE_W-1:0]  wcnt;
  logic [AGE_W-1:0]  ras_age;
  logic [AGE_W-1:0]  cas_age;
  logic [ROW_W-1:0]  open_row;
  logic [HA_W-1:0]   cur_addr;
  logic              cur_wr;
  logic [LANES-1:0]  cur_be;
  logic [DATA_W-1:0] cur_wdata;

  logic [HA_W-1:0]   mux_src;
  logic [ADDR_W-1:1] m_row_up, m_col_up;
  logic              m_row0, m_col0_lo, m_col0_hi;
  logic              ras_fall, cas_fall, close_due, row_hit, strobe_done;

  assign mux_src   = (state == ST_RCD) ? cur_addr : req_addr;
  assign ras_fall  = (state == ST_RSET) && (wcnt == '0);
  assign cas_fall  = (state == ST_COL) && (cas_age >= K_HPC);
  assign close_due = (ras_age >= K_LIM);
  assign row_hit   = (req_addr[HA_W-1:COL_W] == open_row);
  assign strobe_done = cur_wr ? (cas_age >= K_CAS)
                              : ((cas_age >= K_CAC) && (ras_age >= K_RAC));

  edo_addr_mux #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .INTERLEAVE(INTERLEAVE)
  ) mux_i (
    .host_addr  (mux_src),
    .row_upper  (m_row_up),
    .row_bit0   (m_row0),
    .col_upper  (m_col_up),
    .col_bit0_lo(m_col0_lo),
    .col_bit0_hi(m_col0_hi)
  );

  edo_age_counter #(.W(AGE_W)) ras_age_i (
    .clk(clk), .rst(rst), .clr(ras_fall), .age(ras_age)
  );

  edo_age_counter #(.W(AGE_W)) cas_age_i (
    .clk(clk), .rst(rst), .clr(cas_fall), .age(cas_age)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      wcnt        <= '0;
      open_row    <= '0;
      cur_addr    <= '0;
      cur_wr      <= 1'b0;
      cur_be      <= '0;
      cur_wdata   <= '0;
      req_ack     <= 1'b0;
      rsp_rdata   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= '1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_a0_lo  <= 1'b0;
      dram_a0_hi  <= 1'b0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr   <= req_addr;
            cur_wr     <= req_write;
            cur_be     <= req_be;
            cur_wdata  <= req_wdata;
            open_row   <= req_addr[HA_W-1:COL_W];
            dram_addr  <= m_row_up;
            dram_a0_lo <= m_row0;
            dram_a0_hi <= m_row0;
            wcnt       <= K_ASR;
            state      <= ST_RSET;
          end
        end
        ST_RSET: begin
          if (wcnt == '0) begin
            dram_ras_n <= 1'b0;
            wcnt       <= K_RCD;
            state      <= ST_RCD;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_RCD: begin
          if (wcnt == '0) begin
            dram_addr   <= m_col_up;
            dram_a0_lo  <= m_col0_lo;
            dram_a0_hi  <= m_col0_hi;
            dram_we_n   <= ~cur_wr;
            dram_oe_n   <= cur_wr;
            dram_dq_oe  <= cur_wr;
            dram_dq_out <= cur_wdata;
            state       <= ST_COL;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_COL: begin
          if (cas_fall) begin
            dram_cas_n <= cur_wr ? ~cur_be : '0;
            state      <= ST_CASL;
          end
        end
        ST_CASL: begin
          if (strobe_done) begin
            if (!cur_wr) rsp_rdata <= dram_dq_in;
            dram_cas_n <= '1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            req_ack    <= 1'b1;
            wcnt       <= K_CP;
            state      <= ST_CASH;
          end
        end
        ST_CASH: begin
          if (wcnt == '0) state <= ST_PAGE;
          else            wcnt  <= wcnt - 1'b1;
        end
        ST_PAGE: begin
          if (req_valid && !close_due && row_hit) begin
            cur_addr    <= req_addr;
            cur_wr      <= req_write;
            cur_be      <= req_be;
            cur_wdata   <= req_wdata;
            dram_addr   <= m_col_up;
            dram_a0_lo  <= m_col0_lo;
            dram_a0_hi  <= m_col0_hi;
            dram_we_n   <= ~req_write;
            dram_oe_n   <= req_write;
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            state       <= ST_COL;
          end else if ((req_valid || close_due) && (ras_age >= K_RAS)) begin
            dram_ras_n <= 1'b1;
            wcnt       <= K_RP;
            state      <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (wcnt != '0)          wcnt  <= wcnt - 1'b1;
          else if (ras_age >= K_RC) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_page_sequencer_chk.sv
module edo_page_sequencer_chk #(
  parameter int ADDR_W    = 12,
  parameter int LANES     = 8,
  parameter int CLK_NS    = 10,
  parameter int T_RP_NS   = 40,
  parameter int T_RASP_NS = 100000
) (
  input logic              clk,
  input logic              rst,
  input logic              dram_ras_n,
  input logic [LANES-1:0]  dram_cas_n,
  input logic              dram_we_n,
  input logic [ADDR_W-1:1] dram_addr,
  input logic              dram_a0_lo,
  input logic              dram_a0_hi,
  input logic              req_ack
);
  localparam int RP_C   = (T_RP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RASP_C = T_RASP_NS / CLK_NS;

  int unsigned lo_cnt;
  int unsigned hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= 0;
      hi_cnt <= RP_C;
    end else if (dram_ras_n) begin
      lo_cnt <= 0;
      if (hi_cnt < RP_C + 1) hi_cnt <= hi_cnt + 1;
    end else begin
      hi_cnt <= 0;
      lo_cnt <= lo_cnt + 1;
    end
  end

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  // R2
  row_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> ($stable(dram_addr) && (dram_a0_lo == dram_a0_hi)));

  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (rst)
    ((dram_cas_n != '1) && ($past(dram_cas_n) == '1) && !dram_we_n) |-> !$past(dram_we_n));

  // R9
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (rst)
    (dram_cas_n != '1) |-> !dram_ras_n);

  // R10
  ras_window_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> (lo_cnt < RASP_C));

  // R8
  precharge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (hi_cnt >= RP_C));
endmodule

bind edo_page_sequencer edo_page_sequencer_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .CLK_NS(CLK_NS),
  .T_RP_NS(T_RP_NS), .T_RASP_NS(T_RASP_NS)
) chk_i (
  .clk(clk), .rst(rst), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_a0_lo(dram_a0_lo),
  .dram_a0_hi(dram_a0_hi), .req_ack(req_ack)
);

// File: tb/edo_page_sequencer_tb.sv
`timescale 1ns/1ps
module edo_page_sequencer_tb_top;
  localparam int ROW_W = 3;
  localparam int COL_W = 4;
  localparam int AW    = 4;
  localparam int RASP  = 600;
  localparam int NW    = 1 << (ROW_W + COL_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic                   req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [63:0]            req_wdata = '0;
  logic [7:0]             req_be = '0;
  logic                   req_ack;
  logic [63:0]            rsp_rdata;
  logic                   ras_n, we_n, oe_n, a0_lo, a0_hi, dq_oe;
  logic [7:0]             cas_n;
  logic [AW-1:1]          addr;
  logic [63:0]            dq_out;
  logic [63:0]            dq_in = '0;

  edo_page_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RASP_NS(RASP)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(addr), .dram_a0_lo(a0_lo), .dram_a0_hi(a0_hi),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int n_chk = 0, n_bad = 0, ras_falls = 0;
  logic [31:0] lo_mem [NW], hi_mem [NW];   // memory model, pin-addressed
  logic [31:0] ref_lo [NW], ref_hi [NW];   // expected contents, host-addressed

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_word(input int idx, input int half);
    return 32'h9E37_79B9 * (idx + 1) ^ (half ? 32'h5A5A_0F0F : 32'h0123_4567);
  endfunction

  // ---------------- memory model with timing monitor ----------------
  longint t_rf = -1000, t_rr = -1000, t_cf = -1000, t_cr = -1000;
  logic p_ras = 1'b1, p_cas = 1'b0, p_we = 1'b1, p_dqoe = 1'b0;
  logic [AW-1:1] p_addr = '0;
  logic [63:0] p_dq = '0;
  logic [ROW_W-1:0] m_row = '0;
  logic [COL_W-1:0] m_col_lo = '0, m_col_hi = '0;

  always @(negedge clk) begin
    longint now;
    logic cas_any;
    now = $time - 5;
    cas_any = (cas_n != 8'hFF);
    if (!rst) begin
      if (p_ras && !ras_n) begin
        chk(addr == p_addr && a0_lo == a0_hi, "R2 row setup", {60'd0, addr}, {60'd0, p_addr});
        chk(now - t_rr >= 40, "R8 precharge ns", now - t_rr, 40);
        chk(now - t_rf >= 104, "R8 cycle ns", now - t_rf, 104);
        t_rf = now;
        m_row = ROW_W'({addr, a0_lo});
        ras_falls++;
      end
      if (!p_ras && ras_n) begin
        chk(now - t_rf >= 60, "R11 ras low ns", now - t_rf, 60);
        chk(now - t_rf <= RASP, "R10 ras low ns", now - t_rf, RASP);
        t_rr = now;
      end
      if (!p_cas && cas_any) begin
        chk(!ras_n, "R9 cas under ras", {63'd0, ras_n}, 0);
        chk(now - t_cr >= 10 && now - t_cf >= 25, "R9 cas gap ns", now - t_cf, 25);
        chk(a0_hi == ~a0_lo, "R3 split a0", {63'd0, a0_hi}, {63'd0, ~a0_lo});
        t_cf = now;
        m_col_lo = {addr, a0_lo};
        m_col_hi = {addr, a0_hi};
        if (!we_n) begin
          chk(!p_we && p_dqoe && dq_oe && p_dq == dq_out, "R4 write setup", p_dq, dq_out);
          for (int i = 0; i < 8; i++) begin
            if (!cas_n[i]) begin
              if (i < 4) lo_mem[{m_row, m_col_lo}][i*8 +: 8] = dq_out[i*8 +: 8];
              else       hi_mem[{m_row, m_col_hi}][(i-4)*8 +: 8] = dq_out[i*8 +: 8];
            end
          end
        end
      end
      if (p_cas && !cas_any) begin
        chk(now - t_cf >= 10, "R9 cas width ns", now - t_cf, 10);
        t_cr = now;
      end
      if (!ras_n && cas_any && we_n && !oe_n && ($time - t_rf >= 60) && ($time - t_cf >= 20))
        dq_in = {hi_mem[{m_row, m_col_hi}], lo_mem[{m_row, m_col_lo}]};
      else
        dq_in = 64'hBADD_BADD_BADD_BADD;
    end
    p_ras = ras_n; p_cas = cas_any; p_we = we_n; p_dqoe = dq_oe;
    p_addr = addr; p_dq = dq_out;
  end

  // ---------------- host driver ----------------
  task automatic do_req(input bit wr, input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                        input logic [63:0] wd, input logic [7:0] be);
    int waited;
    logic [63:0] exp;
    logic [COL_W-1:0] colh;
    colh = col ^ 1'b1;
    req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_wdata = wd; req_be = be;
    waited = 0;
    @(negedge clk);
    while (!req_ack && waited < 300) begin waited++; @(negedge clk); end
    chk(req_ack, "R6 ack seen", {63'd0, req_ack}, 1);
    exp = {ref_hi[{row, colh}], ref_lo[{row, col}]};
    if (!wr) chk(rsp_rdata == exp, "R5 read data", rsp_rdata, exp);
    else begin
      for (int i = 0; i < 8; i++)
        if (be[i]) begin
          if (i < 4) ref_lo[{row, col}][i*8 +: 8] = wd[i*8 +: 8];
          else       ref_hi[{row, colh}][(i-4)*8 +: 8] = wd[i*8 +: 8];
        end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ack, "R6 single pulse", {63'd0, req_ack}, 0);
  endtask

  bit done = 1'b0;

  initial begin
    int f0;
    logic [ROW_W-1:0] row;
    for (int i = 0; i < NW; i++) begin
      lo_mem[i] = seed_word(i, 0); ref_lo[i] = seed_word(i, 0);
      hi_mem[i] = seed_word(i, 1); ref_hi[i] = seed_word(i, 1);
    end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n == 8'hFF && we_n && oe_n && !dq_oe && !req_ack, "R1 reset",
        {ras_n, cas_n, we_n, oe_n, dq_oe, req_ack}, 13'h1FFC);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n == 8'hFF && !req_ack, "R1 after reset", {55'd0, ras_n, cas_n}, {55'd0, 9'h1FF});

    // R3/R5 plain read, then R7 page hit
    do_req(1'b0, 3'd2, 4'd3, '0, '0);
    f0 = ras_falls;
    do_req(1'b0, 3'd2, 4'd4, '0, '0);
    chk(ras_falls == f0, "R7 page hit keeps row", ras_falls, f0);
    // R8 row change
    do_req(1'b0, 3'd5, 4'd0, '0, '0);
    chk(ras_falls == f0 + 1, "R8 new row opens", ras_falls, f0 + 1);
    // R4 single byte lane write then readback
    do_req(1'b1, 3'd1, 4'd6, 64'h1122_3344_5566_7788, 8'h01);
    do_req(1'b0, 3'd1, 4'd6, '0, '0);
    do_req(1'b1, 3'd1, 4'd7, 64'hA5A5_0000_0000_5A5A, 8'h81);
    do_req(1'b0, 3'd1, 4'd7, '0, '0);
    do_req(1'b0, 3'd1, 4'd6, '0, '0);
    // R10 long burst on one row forces the page closed
    f0 = ras_falls;
    for (int i = 0; i < 20; i++) do_req(1'b0, 3'd4, COL_W'(i), '0, '0);
    chk(ras_falls > f0 + 1, "R10 forced close", ras_falls, f0 + 2);

    // random mix
    row = 3'd0;
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 4 == 0) row = ROW_W'($urandom);
      do_req(($urandom % 2) == 1, row, COL_W'($urandom),
             {$urandom, $urandom}, 8'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    // idle page closes by itself
    repeat (80) @(negedge clk);
    chk(ras_n, "R10 idle page closed", {63'd0, ras_n}, 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule